// File: doc/BRIEF.md
# Receive Sample Phase Tuning Sweep Controller

This block picks a receive sample phase for a storage-card host interface without software stepping through the settings. When started, it walks a 32-step delay setting upward from zero. For each setting it performs a read-modify-write of a 32-bit control register, replacing only a 5-bit phase field. It then waits a programmable settle time and clears the low interrupt status bits. Finally it asks an external command engine for one tuning transfer and records whether that transfer passed.

The sweep locks onto the first contiguous run of passing settings. The first failure after that run ends the sweep at once. The block then programs the integer midpoint of the run, using the same write, settle and clear sequence, and pulses a done strobe. If no setting passed, phase zero is programmed and an error flag is raised.

The tuning transfer itself, the data pattern comparison and the analog delay line lie outside the block. They are seen only through a request/done/pass handshake and the register write port.

Top module: `phase_sweep_tuner`

## Requirements
- R1: After reset, ctrlWrEn, intClrEn, attemptReq, tuneDone and tuneError are 0 and phase is 0.
- R2: A tuneStart pulse while idle begins a sweep. Phases are written in ascending order from 0. Each write is a one-cycle ctrlWrEn strobe whose ctrlWrData bits 20:16 hold the phase.
- R3: Every write keeps all ctrlWrData bits outside 20:16 equal to ctrlRdData.
- R4: Exactly SETTLE_CYC+1 cycles after each write strobe, intClrEn pulses for one cycle with intClrMask = 32'h0001_FFFF, which has the 17 low bits set.
- R5: attemptReq rises in the cycle after that clear strobe and stays high until attemptDone is seen. attemptPass is sampled in the attemptDone cycle.
- R6: A failing attempt before any pass is ignored, and the sweep moves on to the next phase.
- R7: The first passing phase becomes the window start. Later passes do not move it.
- R8: The first failure after a window start ends the sweep, with window end = failing phase - 1. No further attempt is requested.
- R9: If phase 31 is reached with no failure after the window start, the window end is 31.
- R10: With a window, the final phase is floor((start+end)/2). It is written, settled and cleared like any other phase, then tuneDone pulses for one cycle, in the cycle after the final clear, with tuneError 0.
- R11: With no passing phase, phase 0 is written as the final value and tuneError is 1 together with tuneDone. tuneError stays 1 until the next sweep starts.
- R12: tuneStart is ignored while a sweep is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tuneStart | input | 1 | Begin a sweep (idle only) |
| attemptReq | output | 1 | Request one tuning transfer |
| attemptDone | input | 1 | Transfer finished this cycle |
| attemptPass | input | 1 | Transfer result, valid with attemptDone |
| ctrlRdData | input | 32 | Current control register contents |
| ctrlWrEn | output | 1 | Control register write strobe |
| ctrlWrData | output | 32 | Merged control register write value |
| intClrEn | output | 1 | Interrupt status clear strobe |
| intClrMask | output | 32 | Write-one-to-clear mask |
| phase | output | 5 | Phase currently programmed |
| tuneDone | output | 1 | Sweep finished (one-cycle pulse) |
| tuneError | output | 1 | No passing phase found |

## Verification
The assertions assume that attemptDone is raised only while attemptReq is high, that it lasts a single cycle, and that ctrlRdData reflects the last value written. The bench's responder drives attemptDone only after it has seen attemptReq high for a few cycles, and drops it on the next cycle. A bench register model feeds every write back into ctrlRdData. Pass patterns come from fixed vectors indexed by the phase the bench last saw written, so each transfer result is known before the sweep starts.

// File: rtl/phase_sweep_pkg.sv
package phase_sweep_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WRITE,
    S_SETTLE,
    S_CLEAR,
    S_ATTEMPT,
    S_RESOLVE,
    S_FINISH
  } sweep_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSweep;
    logic stepPhase;
    logic markStart;
    logic closeAtFail;
    logic closeAtTop;
    logic loadFinal;
    logic settleLoad;
  } dp_cmd_t;

endpackage

// File: rtl/sweep_dpath.sv
module sweep_dpath
  import phase_sweep_pkg::*;
#(
  parameter int PHASE_BITS = 5,
  parameter int PHASE_LSB  = 16,
  parameter int REG_W      = 32,
  parameter int INT_BITS   = 17,
  parameter int SETTLE_CYC = 50000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_cmd_t               cmd,
  input  logic [REG_W-1:0]      ctrlRdData,
  output logic [REG_W-1:0]      ctrlWrData,
  output logic [REG_W-1:0]      intClrMask,
  output logic [PHASE_BITS-1:0] phase,
  output logic                  haveStart,
  output logic                  atTop,
  output logic                  settleDone
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [REG_W-1:0] FIELD_MASK =
    REG_W'({PHASE_BITS{1'b1}}) << PHASE_LSB;
  localparam logic [REG_W-1:0] INT_MASK =
    {{(REG_W-INT_BITS){1'b0}}, {INT_BITS{1'b1}}};

  logic [PHASE_BITS-1:0] curPhase;
  logic [PHASE_BITS-1:0] winStart;
  logic [PHASE_BITS-1:0] winEnd;
  logic [PHASE_BITS:0]   winSum;
  logic [PHASE_BITS-1:0] winMid;
  logic [CW-1:0]         settleCnt;

  assign winSum = {1'b0, winStart} + {1'b0, winEnd};
  assign winMid = winSum[PHASE_BITS:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPhase  <= '0;
      winStart  <= '0;
      winEnd    <= '0;
      haveStart <= 1'b0;
    end else if (cmd.clrSweep) begin
      curPhase  <= '0;
      winStart  <= '0;
      winEnd    <= '0;
      haveStart <= 1'b0;
    end else begin
      if (cmd.markStart) begin
        winStart  <= curPhase;
        haveStart <= 1'b1;
      end
      if (cmd.closeAtFail) winEnd <= curPhase - 1'b1;
      if (cmd.closeAtTop)  winEnd <= curPhase;
      if (cmd.stepPhase)   curPhase <= curPhase + 1'b1;
      if (cmd.loadFinal)   curPhase <= haveStart ? winMid : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                settleCnt <= '0;
    else if (cmd.settleLoad)  settleCnt <= CW'(SETTLE_CYC);
    else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end

  assign settleDone = (settleCnt == CW'(1));
  assign atTop      = (curPhase == {PHASE_BITS{1'b1}});
  assign phase      = curPhase;
  assign ctrlWrData = (ctrlRdData & ~FIELD_MASK) | (REG_W'(curPhase) << PHASE_LSB);
  assign intClrMask = INT_MASK;

  // R7: once a window start is held, it does not move until the next sweep
  a_r7_start_stable: assert property (@(posedge clk) disable iff (!rstN)
    haveStart && !cmd.clrSweep |=> $stable(winStart));

  // R8: a closed window never ends before it starts
  a_r8_window_order: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadFinal && haveStart |-> winEnd >= winStart);

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import phase_sweep_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tuneStart,
  input  logic    attemptDone,
  input  logic    attemptPass,
  input  logic    haveStart,
  input  logic    atTop,
  input  logic    settleDone,
  output dp_cmd_t cmd,
  output logic    ctrlWrEn,
  output logic    intClrEn,
  output logic    attemptReq,
  output logic    tuneDone,
  output logic    tuneError
);

  sweep_state_t state, stateNxt;
  logic finalPass, finalPassNxt;
  logic errNxt;

  always_comb begin
    stateNxt     = state;
    finalPassNxt = finalPass;
    errNxt       = tuneError;
    cmd          = '0;
    ctrlWrEn     = 1'b0;
    intClrEn     = 1'b0;
    attemptReq   = 1'b0;
    tuneDone     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (tuneStart) begin
          cmd.clrSweep = 1'b1;
          finalPassNxt = 1'b0;
          errNxt       = 1'b0;
          stateNxt     = S_WRITE;
        end
      end
      S_WRITE: begin
        ctrlWrEn       = 1'b1;
        cmd.settleLoad = 1'b1;
        stateNxt       = S_SETTLE;
      end
      S_SETTLE: begin
        if (settleDone) stateNxt = S_CLEAR;
      end
      S_CLEAR: begin
        intClrEn = 1'b1;
        stateNxt = finalPass ? S_FINISH : S_ATTEMPT;
      end
      S_ATTEMPT: begin
        attemptReq = 1'b1;
        if (attemptDone) begin
          if (attemptPass && !haveStart) cmd.markStart = 1'b1;
          if (!attemptPass && haveStart) begin
            cmd.closeAtFail = 1'b1;
            stateNxt        = S_RESOLVE;
          end else if (atTop) begin
            cmd.closeAtTop = 1'b1;
            stateNxt       = S_RESOLVE;
          end else begin
            cmd.stepPhase = 1'b1;
            stateNxt      = S_WRITE;
          end
        end
      end
      S_RESOLVE: begin
        cmd.loadFinal = 1'b1;
        finalPassNxt  = 1'b1;
        errNxt        = !haveStart;
        stateNxt      = S_WRITE;
      end
      S_FINISH: begin
        tuneDone = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      finalPass <= 1'b0;
      tuneError <= 1'b0;
    end else begin
      state     <= stateNxt;
      finalPass <= finalPassNxt;
      tuneError <= errNxt;
    end
  end

  // R5: a pending request is held until the engine answers
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    attemptReq && !attemptDone |=> attemptReq);

  // R10: completion follows the last status clear directly
  a_r10_done_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    tuneDone |-> $past(intClrEn));

endmodule

// File: rtl/phase_sweep_tuner.sv
module phase_sweep_tuner
  import phase_sweep_pkg::*;
#(
  parameter int PHASE_BITS = 5,
  parameter int PHASE_LSB  = 16,
  parameter int REG_W      = 32,
  parameter int INT_BITS   = 17,
  parameter int SETTLE_CYC = 50000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tuneStart,
  output logic                  attemptReq,
  input  logic                  attemptDone,
  input  logic                  attemptPass,
  input  logic [REG_W-1:0]      ctrlRdData,
  output logic                  ctrlWrEn,
  output logic [REG_W-1:0]      ctrlWrData,
  output logic                  intClrEn,
  output logic [REG_W-1:0]      intClrMask,
  output logic [PHASE_BITS-1:0] phase,
  output logic                  tuneDone,
  output logic                  tuneError
);

  localparam int CW = $clog2(SETTLE_CYC + 1);

  dp_cmd_t cmd;
  logic    haveStart;
  logic    atTop;
  logic    settleDone;

  sweep_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tuneStart   (tuneStart),
    .attemptDone (attemptDone),
    .attemptPass (attemptPass),
    .haveStart   (haveStart),
    .atTop       (atTop),
    .settleDone  (settleDone),
    .cmd         (cmd),
    .ctrlWrEn    (ctrlWrEn),
    .intClrEn    (intClrEn),
    .attemptReq  (attemptReq),
    .tuneDone    (tuneDone),
    .tuneError   (tuneError)
  );

  sweep_dpath #(
    .PHASE_BITS (PHASE_BITS),
    .PHASE_LSB  (PHASE_LSB),
    .REG_W      (REG_W),
    .INT_BITS   (INT_BITS),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .ctrlRdData (ctrlRdData),
    .ctrlWrData (ctrlWrData),
    .intClrMask (intClrMask),
    .phase      (phase),
    .haveStart  (haveStart),
    .atTop      (atTop),
    .settleDone (settleDone)
  );

  // cycle count since the last write strobe, kept for the settle check
  logic [CW:0] sinceWr;
  always_ff @(posedge clk) begin
    if (!rstN)                   sinceWr <= '0;
    else if (ctrlWrEn)           sinceWr <= (CW+1)'(1);
    else if (sinceWr != '1)      sinceWr <= sinceWr + 1'b1;
  end

  // R4: status clear comes exactly one settle interval after the write
  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rstN)
    intClrEn |-> sinceWr == (CW+1)'(SETTLE_CYC + 1));

  // R11: an error completion leaves phase zero programmed
  a_r11_err_phase_zero: assert property (@(posedge clk) disable iff (!rstN)
    tuneDone && tuneError |-> phase == '0);

endmodule

// File: tb/sim_phase_sweep_tuner.sv
module sim_phase_sweep_tuner;

  localparam int SETTLE = 6;
  localparam logic [31:0] BASE  = 32'hC3A5_5A3C;
  localparam logic [31:0] FMASK = 32'h001F_0000;
  localparam logic [31:0] OTHER = BASE & ~FMASK;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tuneStart = 1'b0;
  logic        attemptReq;
  logic        attemptDone = 1'b0;
  logic        attemptPass = 1'b0;
  logic [31:0] ctrlRdData;
  logic        ctrlWrEn;
  logic [31:0] ctrlWrData;
  logic        intClrEn;
  logic [31:0] intClrMask;
  logic [4:0]  phase;
  logic        tuneDone;
  logic        tuneError;

  always #10 clk = ~clk;

  phase_sweep_tuner #(.SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .tuneStart(tuneStart), .attemptReq(attemptReq),
    .attemptDone(attemptDone), .attemptPass(attemptPass), .ctrlRdData(ctrlRdData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .intClrEn(intClrEn),
    .intClrMask(intClrMask), .phase(phase), .tuneDone(tuneDone), .tuneError(tuneError)
  );

  // control register model fed back as read data
  logic [31:0] regModel;
  always_ff @(posedge clk) begin
    if (!rstN)         regModel <= BASE;
    else if (ctrlWrEn) regModel <= ctrlWrData;
  end
  assign ctrlRdData = regModel;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  bit expErr;
  int expFinal;
  int expAttempts;
  int attempts;
  bit doneSeen;
  bit [31:0] pattern;
  int sinceWr = 0;
  int sinceClr = 0;
  bit prevClr = 1'b0;
  bit prevReq = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes and checks strobes as they appear
  always @(negedge clk) begin
    if (rstN) begin
      sinceWr++;
      sinceClr++;
      if (ctrlWrEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12", "unexpected write", ctrlWrData[20:16], 0);
        end else begin
          int e;
          e = expQ.pop_front();
          check(ctrlWrData[20:16] == 5'(e), "R2", "written phase", ctrlWrData[20:16], e);
          check((ctrlWrData & ~FMASK) == OTHER, "R3", "other bits", ctrlWrData & ~FMASK, OTHER);
        end
        sinceWr = 0;
      end
      if (intClrEn) begin
        check(sinceWr == SETTLE + 1, "R4", "settle gap", sinceWr, SETTLE + 1);
        check(intClrMask == 32'h0001_FFFF, "R4", "clear mask", intClrMask, 32'h0001_FFFF);
        sinceClr = 0;
      end
      if (attemptReq && !prevReq) begin
        attempts++;
        check(prevClr, "R5", "request after clear", prevClr, 1);
      end
      if (tuneDone) begin
        check(sinceClr == 1, "R10", "done after clear", sinceClr, 1);
        check(phase == 5'(expFinal), expErr ? "R11" : "R10", "final phase", phase, expFinal);
        check(tuneError == expErr, "R11", "error flag", tuneError, expErr);
        check(expQ.size() == 0, "R10", "writes left", expQ.size(), 0);
        check(attempts == expAttempts, "R8", "attempt count", attempts, expAttempts);
        doneSeen = 1'b1;
      end
      prevClr = intClrEn;
      prevReq = attemptReq;
    end
  end

  // responder: answers each request after a short delay
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && attemptReq && !attemptDone) begin
        repeat (2) @(negedge clk);
        check(attemptReq, "R5", "request held", attemptReq, 1);
        attemptDone = 1'b1;
        attemptPass = pattern[regModel[20:16]];
        @(negedge clk);
        attemptDone = 1'b0;
        attemptPass = 1'b0;
      end
    end
  end

  // driver: builds the expected write sequence, then runs the sweep
  task automatic runTune(input bit [31:0] pat, input bit extraStart, input string tag);
    int s = -1;
    int e = -1;
    bit ended = 1'b0;
    expQ.delete();
    for (int p = 0; p < 32; p++) begin
      expQ.push_back(p);
      if (pat[p] && s < 0) s = p;
      else if (!pat[p] && s >= 0) begin
        e = p - 1;
        ended = 1'b1;
        break;
      end
    end
    if (!ended && s >= 0) e = 31;
    expAttempts = expQ.size();
    expErr   = (s < 0);
    expFinal = (s < 0) ? 0 : (s + e) / 2;
    expQ.push_back(expFinal);
    pattern  = pat;
    attempts = 0;
    doneSeen = 1'b0;
    @(negedge clk); tuneStart = 1'b1;
    @(negedge clk); tuneStart = 1'b0;
    if (extraStart) begin
      repeat (40) @(negedge clk);
      tuneStart = 1'b1;
      @(negedge clk); tuneStart = 1'b0;
    end
    while (!doneSeen) @(negedge clk);
    repeat (5) @(negedge clk);
    check(phase == 5'(expFinal), tag, "result held", phase, expFinal);
    check(tuneError == expErr, "R11", "error held", tuneError, expErr);
    check(!attemptReq && !ctrlWrEn, "R8", "quiet after done", {attemptReq, ctrlWrEn}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({ctrlWrEn, intClrEn, attemptReq, tuneDone, tuneError} == 5'b0, "R1",
          "strobes after reset", {ctrlWrEn, intClrEn, attemptReq, tuneDone, tuneError}, 0);
    check(phase == 5'd0, "R1", "phase after reset", phase, 0);

    runTune(32'h0000_03E0, 1'b0, "R6");   // window 5..9, fails before it
    runTune(32'h0000_0000, 1'b0, "R11");  // nothing passes
    runTune(32'hF000_0000, 1'b0, "R9");   // window 28..31
    runTune(32'hFFFF_FFFF, 1'b0, "R9");   // whole range passes
    runTune(32'h0000_0001, 1'b0, "R8");   // window 0..0, not an error
    runTune(32'h0000_0418, 1'b1, "R12");  // window 3..4, later pass at 10, start while busy
    runTune(32'h0000_0D98, 1'b0, "R7");   // 3,4 pass; 7,8,10,11 ignored
    runTune(32'h8000_0000, 1'b0, "R9");   // single pass at top

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule